// File: doc/BRIEF.md
# Ingress Virtual Output Queue Manager

This block sits on the receive side of a switching element and holds packet descriptors until the egress side agrees to take them. Each destination port and traffic class pair owns one logical queue. The queues are singly linked lists threaded through one shared pointer memory, and a bitmap allocator hands out free entries. When a descriptor is accepted, the block emits a credit request naming its queue. The egress scheduler later answers with a grant for that queue, and the grant pops exactly one descriptor from the head of the queue. Local and remote destinations are handled the same way.

On admission the block picks a storage tier for the packet. If the queue held nothing when the packet arrived, the packet goes to the small fast on-chip tier. Otherwise it goes to the large external tier. The chosen tier travels with the descriptor and appears on the dequeue output. Two checks guard admission. The first is a per-queue depth limit that a register write port can change. The second is a partition of the entry space into three parts: a reserved quota for each queue, a pool for multi-destination traffic, and a shared pool that unicast traffic uses once its reserved quota is spent.

Top module: `vq_manager`

## Requirements
- R1: The queue index is `port * NUM_TC + tc` (8 queues by default). The cycle after an accepted descriptor, `req_valid` pulses for one cycle with `req_qid` set to that index.
- R2: A descriptor leaves only in response to a grant. `deq_valid` is high only in the cycle after a `gnt_valid` whose queue was non-empty, and each such grant releases exactly one descriptor.
- R3: Within a queue, descriptors leave in arrival order. Traffic in one queue does not change the order or the content of another queue.
- R4: `deq_tier` is 0 (fast on-chip) when the queue held no descriptor in the arrival cycle and 1 (external) otherwise. This holds even when the same cycle's grant empties the queue.
- R5: An arrival is dropped when its queue already holds at least its limit. Limits reset to `DEFAULT_LIMIT` (8) and are rewritten by `cfg_we` with `cfg_qid` and `cfg_limit`. A limit of 0 drops every arrival.
- R6: A unicast arrival first uses its queue's reserved quota (`RSV_PER_Q`, 1). When that quota is spent it uses the shared pool (`SHARED_POOL`, 19). With both spent, the arrival is dropped.
- R7: A multi-destination arrival (`in_mcast` = 1) uses only its own pool (`MC_POOL`, 5). It is independent of the shared pool and of the reserved quotas.
- R8: A dropped arrival raises no request and increments its queue's 8-bit saturating drop count. The count for queue q is `drop_counts[q*8 +: 8]`.
- R9: A grant for an empty queue releases nothing. The next cycle `gnt_err` pulses, and the 8-bit saturating `gnt_err_count` increments.
- R10: A released entry is returned to its pool and to the free memory, so later arrivals to a drained queue are admitted again.
- R11: After reset every queue is empty, and no request, release or error is flagged. All counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Descriptor arrival strobe |
| in_port | input | 2 | Destination output port |
| in_tc | input | 1 | Traffic class |
| in_mcast | input | 1 | Multi-destination descriptor |
| in_desc | input | 16 | Descriptor contents (buffer handle) |
| req_valid | output | 1 | Credit request pulse |
| req_qid | output | 3 | Queue the request is for |
| gnt_valid | input | 1 | Grant strobe from egress |
| gnt_qid | input | 3 | Granted queue |
| deq_valid | output | 1 | Released descriptor valid |
| deq_qid | output | 3 | Queue of the released descriptor |
| deq_desc | output | 16 | Released descriptor |
| deq_tier | output | 1 | 0 on-chip tier, 1 external tier |
| cfg_we | input | 1 | Limit register write |
| cfg_qid | input | 3 | Queue whose limit is written |
| cfg_limit | input | 6 | New depth limit |
| gnt_err | output | 1 | Grant hit an empty queue |
| gnt_err_count | output | 8 | Saturating count of such grants |
| drop_counts | output | 64 | Per-queue saturating drop counts, 8 bits each |

## Verification
A broken link pointer or head register shows up on the first grant that reaches the damaged node: the released descriptor belongs to another queue or comes out of order. This is caught one cycle after that grant. A queue count that drifts shows up as a spurious `gnt_err` on a queue that still holds data, or as a release from a queue that should be empty. A pool counter that fails to return entries shows up later, as drops on a drained queue. The directed cases therefore drain every queue they fill and then refill it.

// File: rtl/vq_pkg.sv
package vq_pkg;

  // Which partition of the entry space an admitted descriptor consumes.
  typedef enum logic [1:0] {
    POOL_RSV = 2'd0,
    POOL_SHR = 2'd1,
    POOL_MC  = 2'd2
  } pool_e;

  // Storage tier chosen on arrival.
  typedef enum logic {
    TIER_FAST = 1'b0,
    TIER_BULK = 1'b1
  } tier_e;

endpackage

// File: rtl/vq_free_list.sv
module vq_free_list #(
  parameter  int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             free_en,
  input  logic [IDX_W-1:0] free_idx,
  output logic [IDX_W-1:0] alloc_idx
);

  logic [DEPTH-1:0] free_q, free_d;
  logic             free_upd;

  // lowest free entry wins
  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_idx = IDX_W'(i);
    end
  end

  always_comb begin
    free_d = free_q;
    if (alloc_en) free_d[alloc_idx] = 1'b0;
    if (free_en)  free_d[free_idx]  = 1'b1;
  end

  assign free_upd = alloc_en | free_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        free_q <= '1;
    else if (free_upd) free_q <= free_d;
  end

  // R10: an entry is only taken when one exists, and only returned when held
  p_alloc_has_space_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (|free_q));
  p_free_only_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> !free_q[free_idx]);

endmodule

// File: rtl/vq_link_store.sv
module vq_link_store
  import vq_pkg::*;
#(
  parameter  int DEPTH  = 32,
  parameter  int DESC_W = 16,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DESC_W-1:0] wr_desc,
  input  tier_e             wr_tier,
  input  pool_e             wr_pool,
  input  logic              lnk_en,
  input  logic [IDX_W-1:0]  lnk_idx,
  input  logic [IDX_W-1:0]  lnk_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DESC_W-1:0] rd_desc,
  output tier_e             rd_tier,
  output pool_e             rd_pool,
  output logic [IDX_W-1:0]  rd_next
);

  // payload-side storage: contents only meaningful while an entry is linked
  logic [DESC_W-1:0] ent_desc [DEPTH];
  tier_e             ent_tier [DEPTH];
  pool_e             ent_pool [DEPTH];
  logic [IDX_W-1:0]  ent_next [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_desc[wr_idx] <= wr_desc;
      ent_tier[wr_idx] <= wr_tier;
      ent_pool[wr_idx] <= wr_pool;
    end
    if (lnk_en) ent_next[lnk_idx] <= lnk_val;
  end

  assign rd_desc = ent_desc[rd_idx];
  assign rd_tier = ent_tier[rd_idx];
  assign rd_pool = ent_pool[rd_idx];
  assign rd_next = ent_next[rd_idx];

endmodule

// File: rtl/vq_admit.sv
module vq_admit
  import vq_pkg::*;
#(
  parameter  int NUM_Q       = 8,
  parameter  int DEPTH       = 32,
  parameter  int RSV_PER_Q   = 1,
  parameter  int MC_POOL     = 5,
  parameter  int SHARED_POOL = 19,
  localparam int QID_W       = $clog2(NUM_Q),
  localparam int CW          = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arr_valid,
  input  logic [QID_W-1:0] arr_qid,
  input  logic             arr_mc,
  input  logic [CW-1:0]    arr_count,
  input  logic [CW-1:0]    arr_limit,
  input  logic             rel_en,
  input  logic [QID_W-1:0] rel_qid,
  input  pool_e            rel_pool,
  output logic             admit,
  output pool_e            adm_pool
);

  logic [CW-1:0] rsv_q [NUM_Q];
  logic [CW-1:0] rsv_d [NUM_Q];
  logic [CW-1:0] shr_q, shr_d, mc_q, mc_d;
  logic          cnt_upd;

  // decision: depth limit, then own pool for multi-destination,
  // reserved quota then shared pool for unicast
  always_comb begin
    admit    = 1'b0;
    adm_pool = POOL_RSV;
    if (arr_valid && (arr_count < arr_limit)) begin
      if (arr_mc) begin
        if (mc_q < CW'(MC_POOL)) begin
          admit    = 1'b1;
          adm_pool = POOL_MC;
        end
      end else if (rsv_q[arr_qid] < CW'(RSV_PER_Q)) begin
        admit    = 1'b1;
        adm_pool = POOL_RSV;
      end else if (shr_q < CW'(SHARED_POOL)) begin
        admit    = 1'b1;
        adm_pool = POOL_SHR;
      end
    end
  end

  always_comb begin
    shr_d = shr_q;
    mc_d  = mc_q;
    for (int i = 0; i < NUM_Q; i++) rsv_d[i] = rsv_q[i];
    if (admit) begin
      case (adm_pool)
        POOL_RSV: rsv_d[arr_qid] = rsv_d[arr_qid] + CW'(1);
        POOL_SHR: shr_d = shr_d + CW'(1);
        POOL_MC:  mc_d  = mc_d + CW'(1);
        default:  ;
      endcase
    end
    if (rel_en) begin
      case (rel_pool)
        POOL_RSV: rsv_d[rel_qid] = rsv_d[rel_qid] - CW'(1);
        POOL_SHR: shr_d = shr_d - CW'(1);
        POOL_MC:  mc_d  = mc_d - CW'(1);
        default:  ;
      endcase
    end
  end

  assign cnt_upd = admit | rel_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr_q <= '0;
      mc_q  <= '0;
      for (int i = 0; i < NUM_Q; i++) rsv_q[i] <= '0;
    end else if (cnt_upd) begin
      shr_q <= shr_d;
      mc_q  <= mc_d;
      for (int i = 0; i < NUM_Q; i++) rsv_q[i] <= rsv_d[i];
    end
  end

  // R6: shared pool never overdrawn nor released below zero
  p_shared_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shr_q <= CW'(SHARED_POOL));
  p_shared_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && rel_pool == POOL_SHR) |-> shr_q != '0);
  // R7: multi-destination pool bounded
  p_mc_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mc_q <= CW'(MC_POOL));

endmodule

// File: rtl/vq_manager.sv
module vq_manager
  import vq_pkg::*;
#(
  parameter  int NUM_PORTS     = 4,
  parameter  int NUM_TC        = 2,
  parameter  int DEPTH         = 32,
  parameter  int DESC_W        = 16,
  parameter  int RSV_PER_Q     = 1,
  parameter  int MC_POOL       = 5,
  parameter  int SHARED_POOL   = 19,
  parameter  int DEFAULT_LIMIT = 8,
  parameter  int CNT_W         = 8,
  localparam int PORT_W        = $clog2(NUM_PORTS),
  localparam int TC_W          = $clog2(NUM_TC),
  localparam int NUM_Q         = NUM_PORTS * NUM_TC,
  localparam int QID_W         = $clog2(NUM_Q),
  localparam int IDX_W         = $clog2(DEPTH),
  localparam int LIM_W         = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [PORT_W-1:0]      in_port,
  input  logic [TC_W-1:0]        in_tc,
  input  logic                   in_mcast,
  input  logic [DESC_W-1:0]      in_desc,
  output logic                   req_valid,
  output logic [QID_W-1:0]       req_qid,
  input  logic                   gnt_valid,
  input  logic [QID_W-1:0]       gnt_qid,
  output logic                   deq_valid,
  output logic [QID_W-1:0]       deq_qid,
  output logic [DESC_W-1:0]      deq_desc,
  output logic                   deq_tier,
  input  logic                   cfg_we,
  input  logic [QID_W-1:0]       cfg_qid,
  input  logic [LIM_W-1:0]       cfg_limit,
  output logic                   gnt_err,
  output logic [CNT_W-1:0]       gnt_err_count,
  output logic [NUM_Q*CNT_W-1:0] drop_counts
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // per-queue context
  logic [IDX_W-1:0] head_q [NUM_Q];
  logic [IDX_W-1:0] head_d [NUM_Q];
  logic [IDX_W-1:0] tail_q [NUM_Q];
  logic [IDX_W-1:0] tail_d [NUM_Q];
  logic [LIM_W-1:0] cnt_q  [NUM_Q];
  logic [LIM_W-1:0] cnt_d  [NUM_Q];
  logic [LIM_W-1:0] lim_q  [NUM_Q];
  logic [LIM_W-1:0] lim_d  [NUM_Q];
  logic [CNT_W-1:0] drop_q [NUM_Q];
  logic [CNT_W-1:0] drop_d [NUM_Q];

  logic [QID_W-1:0]  arr_qid;
  logic              adm_ok;
  pool_e             adm_pool;
  logic              enq, gnt_hit, gnt_miss, becomes_head, drop_hit;
  tier_e             enq_tier;
  logic [IDX_W-1:0]  fl_alloc;
  logic [DESC_W-1:0] st_desc;
  tier_e             st_tier;
  pool_e             st_pool;
  logic [IDX_W-1:0]  st_next;
  logic              q_upd, drop_upd;
  logic [CNT_W-1:0]  err_cnt_d;

  always_comb arr_qid = QID_W'(int'(in_port) * NUM_TC + int'(in_tc));

  assign enq      = adm_ok;
  assign gnt_hit  = gnt_valid && (cnt_q[gnt_qid] != '0);
  assign gnt_miss = gnt_valid && (cnt_q[gnt_qid] == '0);
  assign drop_hit = in_valid && !adm_ok;
  assign enq_tier = (cnt_q[arr_qid] == '0) ? TIER_FAST : TIER_BULK;
  // new entry becomes the head if the queue is, or is about to be, empty
  assign becomes_head = (cnt_q[arr_qid] == '0) ||
                        (gnt_hit && (gnt_qid == arr_qid) && (cnt_q[arr_qid] == LIM_W'(1)));

  vq_admit #(
    .NUM_Q       (NUM_Q),
    .DEPTH       (DEPTH),
    .RSV_PER_Q   (RSV_PER_Q),
    .MC_POOL     (MC_POOL),
    .SHARED_POOL (SHARED_POOL)
  ) u_admit (
    .clk       (clk),
    .rst_n     (rst_ni),
    .arr_valid (in_valid),
    .arr_qid   (arr_qid),
    .arr_mc    (in_mcast),
    .arr_count (cnt_q[arr_qid]),
    .arr_limit (lim_q[arr_qid]),
    .rel_en    (gnt_hit),
    .rel_qid   (gnt_qid),
    .rel_pool  (st_pool),
    .admit     (adm_ok),
    .adm_pool  (adm_pool)
  );

  vq_free_list #(.DEPTH(DEPTH)) u_free (
    .clk       (clk),
    .rst_n     (rst_ni),
    .alloc_en  (enq),
    .free_en   (gnt_hit),
    .free_idx  (head_q[gnt_qid]),
    .alloc_idx (fl_alloc)
  );

  vq_link_store #(.DEPTH(DEPTH), .DESC_W(DESC_W)) u_store (
    .clk     (clk),
    .wr_en   (enq),
    .wr_idx  (fl_alloc),
    .wr_desc (in_desc),
    .wr_tier (enq_tier),
    .wr_pool (adm_pool),
    .lnk_en  (enq && !becomes_head),
    .lnk_idx (tail_q[arr_qid]),
    .lnk_val (fl_alloc),
    .rd_idx  (head_q[gnt_qid]),
    .rd_desc (st_desc),
    .rd_tier (st_tier),
    .rd_pool (st_pool),
    .rd_next (st_next)
  );

  // next state of queue contexts
  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      head_d[q] = head_q[q];
      tail_d[q] = tail_q[q];
      cnt_d[q]  = cnt_q[q];
      lim_d[q]  = lim_q[q];
      drop_d[q] = drop_q[q];
    end
    if (gnt_hit) begin
      head_d[gnt_qid] = st_next;
      cnt_d[gnt_qid]  = cnt_d[gnt_qid] - LIM_W'(1);
    end
    if (enq) begin
      tail_d[arr_qid] = fl_alloc;
      cnt_d[arr_qid]  = cnt_d[arr_qid] + LIM_W'(1);
      if (becomes_head) head_d[arr_qid] = fl_alloc;
    end
    if (cfg_we) lim_d[cfg_qid] = cfg_limit;
    if (drop_hit && (drop_q[arr_qid] != '1))
      drop_d[arr_qid] = drop_q[arr_qid] + CNT_W'(1);
  end

  assign q_upd     = enq | gnt_hit;
  assign drop_upd  = drop_hit;
  assign err_cnt_d = (gnt_err_count != '1) ? gnt_err_count + CNT_W'(1) : gnt_err_count;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int q = 0; q < NUM_Q; q++) begin
        head_q[q] <= '0;
        tail_q[q] <= '0;
        cnt_q[q]  <= '0;
        lim_q[q]  <= LIM_W'(DEFAULT_LIMIT);
        drop_q[q] <= '0;
      end
    end else begin
      if (q_upd) begin
        for (int q = 0; q < NUM_Q; q++) begin
          head_q[q] <= head_d[q];
          tail_q[q] <= tail_d[q];
          cnt_q[q]  <= cnt_d[q];
        end
      end
      if (cfg_we) begin
        for (int q = 0; q < NUM_Q; q++) lim_q[q] <= lim_d[q];
      end
      if (drop_upd) begin
        for (int q = 0; q < NUM_Q; q++) drop_q[q] <= drop_d[q];
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid     <= 1'b0;
      req_qid       <= '0;
      deq_valid     <= 1'b0;
      deq_qid       <= '0;
      deq_desc      <= '0;
      deq_tier      <= 1'b0;
      gnt_err       <= 1'b0;
      gnt_err_count <= '0;
    end else begin
      req_valid <= enq;
      deq_valid <= gnt_hit;
      gnt_err   <= gnt_miss;
      if (enq) req_qid <= arr_qid;
      if (gnt_hit) begin
        deq_qid  <= gnt_qid;
        deq_desc <= st_desc;
        deq_tier <= st_tier;
      end
      if (gnt_miss) gnt_err_count <= err_cnt_d;
    end
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_drop
    assign drop_counts[g*CNT_W +: CNT_W] = drop_q[g];
  end

  // R1: every request answers an arrival of the previous cycle
  p_req_after_arrival_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |-> $past(in_valid));
  // R2: a release is always preceded by a grant for the same queue
  p_release_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    deq_valid |-> ($past(gnt_valid) && ($past(gnt_qid) == deq_qid)));
  // R5: the admission unit never lets a queue exceed its limit
  p_limit_respected_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    adm_ok |-> (cnt_q[arr_qid] < lim_q[arr_qid]));
  // R9: a grant to an empty queue flags an error and releases nothing
  p_empty_grant_flag_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (gnt_valid && (cnt_q[gnt_qid] == '0)) |=> (gnt_err && !deq_valid));

endmodule

// File: tb/test_vq_manager.sv
module test_vq_manager;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_mcast, gnt_valid, cfg_we;
  logic [1:0]  in_port;
  logic [0:0]  in_tc;
  logic [15:0] in_desc;
  logic        req_valid, deq_valid, deq_tier, gnt_err;
  logic [2:0]  req_qid, gnt_qid, deq_qid, cfg_qid;
  logic [15:0] deq_desc;
  logic [5:0]  cfg_limit;
  logic [7:0]  gnt_err_count;
  logic [63:0] drop_counts;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  vq_manager i_vq_manager (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port), .in_tc(in_tc),
    .in_mcast(in_mcast), .in_desc(in_desc), .req_valid(req_valid), .req_qid(req_qid),
    .gnt_valid(gnt_valid), .gnt_qid(gnt_qid), .deq_valid(deq_valid), .deq_qid(deq_qid),
    .deq_desc(deq_desc), .deq_tier(deq_tier), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
    .cfg_limit(cfg_limit), .gnt_err(gnt_err), .gnt_err_count(gnt_err_count),
    .drop_counts(drop_counts)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dropc(input int q);
    return int'(drop_counts[q*8 +: 8]);
  endfunction

  task automatic drive_arrival(input int p, input int t, input bit mc, input int d);
    in_valid = 1'b1;
    in_port  = 2'(p);
    in_tc    = 1'(t);
    in_mcast = mc;
    in_desc  = 16'(d);
  endtask

  // one arrival; outputs sampled at the following falling edge
  task automatic send(input int p, input int t, input bit mc, input int d,
                      input bit exp_adm, input string tag);
    @(negedge clk);
    drive_arrival(p, t, mc, d);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " req_valid"}, int'(req_valid), int'(exp_adm));
    if (exp_adm) chk({tag, " req_qid"}, int'(req_qid), p * 2 + t);
  endtask

  task automatic give(input int q, input bit exp_hit, input int exp_d,
                      input int exp_tier, input string tag);
    @(negedge clk);
    gnt_valid = 1'b1;
    gnt_qid   = 3'(q);
    @(negedge clk);
    gnt_valid = 1'b0;
    chk({tag, " deq_valid"}, int'(deq_valid), int'(exp_hit));
    chk({tag, " gnt_err"}, int'(gnt_err), int'(!exp_hit));
    if (exp_hit) begin
      chk({tag, " deq_qid"}, int'(deq_qid), q);
      chk({tag, " deq_desc"}, int'(deq_desc), exp_d);
      chk({tag, " deq_tier"}, int'(deq_tier), exp_tier);
    end
  endtask

  task automatic set_limit(input int q, input int v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_qid   = 3'(q);
    cfg_limit = 6'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic test_reset();
    chk("R11 req_valid", int'(req_valid), 0);
    chk("R11 deq_valid", int'(deq_valid), 0);
    chk("R11 gnt_err", int'(gnt_err), 0);
    chk("R11 err count", int'(gnt_err_count), 0);
    for (int q = 0; q < 8; q++) chk("R11 drop count", dropc(q), 0);
  endtask

  task automatic test_order();
    for (int i = 0; i < 3; i++) send(2, 1, 1'b0, 16'h51 + i, 1'b1, "R1 enqueue q5");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2 no release without grant", int'(deq_valid), 0);
    end
    give(5, 1'b1, 16'h51, 0, "R3/R4 q5 first");
    give(5, 1'b1, 16'h52, 1, "R3/R4 q5 second");
    give(5, 1'b1, 16'h53, 1, "R3/R4 q5 third");
    send(0, 0, 1'b0, 16'h01, 1'b1, "R1 enqueue q0");
    send(3, 1, 1'b0, 16'h71, 1'b1, "R1 enqueue q7");
    give(7, 1'b1, 16'h71, 0, "R3 q7 independent");
    give(0, 1'b1, 16'h01, 0, "R3 q0 independent");
  endtask

  task automatic test_empty_grant();
    give(3, 1'b0, 0, 0, "R9 grant to empty q3");
    chk("R9 error count", int'(gnt_err_count), 1);
    give(5, 1'b0, 0, 0, "R9 grant to drained q5");
    chk("R9 error count again", int'(gnt_err_count), 2);
    send(1, 1, 1'b0, 16'h33, 1'b1, "R9 q3 after bad grant");
    give(3, 1'b1, 16'h33, 0, "R9 q3 intact");
  endtask

  task automatic test_limit();
    set_limit(0, 2);
    send(0, 0, 1'b0, 16'hA0, 1'b1, "R5 q0 first");
    send(0, 0, 1'b0, 16'hA1, 1'b1, "R5 q0 second");
    send(0, 0, 1'b0, 16'hA2, 1'b0, "R5 q0 over limit");
    chk("R8 drop count q0", dropc(0), 1);
    give(0, 1'b1, 16'hA0, 0, "R5 drain q0");
    give(0, 1'b1, 16'hA1, 1, "R5 drain q0");
    set_limit(0, 0);
    send(0, 0, 1'b0, 16'hA3, 1'b0, "R5 zero limit");
    chk("R8 drop count q0 zero limit", dropc(0), 2);
    give(0, 1'b0, 0, 0, "R8 dropped not stored");
    set_limit(0, 8);
  endtask

  task automatic test_pools();
    for (int i = 0; i < 8; i++) send(0, 1, 1'b0, 16'h100 + i, 1'b1, "R6 fill q1");
    for (int i = 0; i < 8; i++) send(1, 0, 1'b0, 16'h200 + i, 1'b1, "R6 fill q2");
    for (int i = 0; i < 8; i++) send(2, 0, 1'b0, 16'h400 + i, i < 6, "R6 fill q4");
    chk("R6/R8 drop count q4", dropc(4), 2);
    send(3, 0, 1'b0, 16'h600, 1'b1, "R6 reserved q6");
    send(0, 0, 1'b1, 16'h0A0, 1'b1, "R7 mc with shared full");
    for (int i = 0; i < 8; i++) give(1, 1'b1, 16'h100 + i, (i == 0) ? 0 : 1, "R3 drain q1");
    for (int i = 0; i < 8; i++) give(2, 1'b1, 16'h200 + i, (i == 0) ? 0 : 1, "R3 drain q2");
    for (int i = 0; i < 6; i++) give(4, 1'b1, 16'h400 + i, (i == 0) ? 0 : 1, "R3 drain q4");
    give(4, 1'b0, 0, 0, "R6 dropped q4 not stored");
    give(6, 1'b1, 16'h600, 0, "R6 drain q6");
    give(0, 1'b1, 16'h0A0, 0, "R7 drain q0");
    for (int i = 0; i < 8; i++) send(2, 0, 1'b0, 16'h480 + i, 1'b1, "R10 refill q4");
    for (int i = 0; i < 8; i++) give(4, 1'b1, 16'h480 + i, (i == 0) ? 0 : 1, "R10 drain q4");
  endtask

  task automatic test_mc();
    for (int i = 0; i < 5; i++) send(3, 1, 1'b1, 16'h700 + i, 1'b1, "R7 mc q7");
    send(3, 1, 1'b1, 16'h705, 1'b0, "R7 mc pool full");
    chk("R7/R8 drop count q7", dropc(7), 1);
    send(3, 1, 1'b0, 16'h706, 1'b1, "R7 unicast unaffected");
    for (int i = 0; i < 5; i++) give(7, 1'b1, 16'h700 + i, (i == 0) ? 0 : 1, "R7 drain q7");
    give(7, 1'b1, 16'h706, 1, "R7 drain q7 unicast");
  endtask

  // arrival to a one-deep queue in the same cycle its head is granted
  task automatic test_same_cycle();
    send(1, 0, 1'b0, 16'hB0, 1'b1, "R4 prime q2");
    @(negedge clk);
    drive_arrival(1, 0, 1'b0, 16'hB1);
    gnt_valid = 1'b1;
    gnt_qid   = 3'd2;
    @(negedge clk);
    in_valid  = 1'b0;
    gnt_valid = 1'b0;
    chk("R4 same cycle req", int'(req_valid), 1);
    chk("R4 same cycle deq", int'(deq_valid), 1);
    chk("R4 same cycle desc", int'(deq_desc), 16'hB0);
    give(2, 1'b1, 16'hB1, 1, "R4 arrival saw non-empty");
    give(2, 1'b0, 0, 0, "R2 one release per grant");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mcast = 1'b0; in_port = '0; in_tc = '0;
    in_desc = '0; gnt_valid = 1'b0; gnt_qid = '0; cfg_we = 1'b0; cfg_qid = '0;
    cfg_limit = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_order();
    test_empty_grant();
    test_limit();
    test_pools();
    test_mc();
    test_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule